// File: doc/BRIEF.md
# Event-Code Delayed Pulse Channel

This block is a single trigger output of a timing receiver. Every clock it sees one 8-bit event code. When that code equals the channel's selected code and the channel is armed, it counts down a delay, then drives a pulse of set width at the chosen active level. Delay and width are counted in ticks of a divided internal clock.

Each event code reaches the receiver at its own fixed offset from the machine fiducial. A 256-entry offset table, indexed by the matched code, is subtracted from the programmed fiducial-to-beam delay before the counter is loaded. Selecting a different code with the right table entry therefore leaves the pulse where it was. A write-only configuration port sets the selected code, arm bit, polarity, delay, width, divider and table entries. Two status outputs report activity and a missed trigger.

Configuration map: address bit 8 set writes offset entry `addr[7:0]`. Address bit 8 clear selects a register by `addr[2:0]`: 0 = selected code, 1 = control (bit 0 arm, bit 1 polarity; a write here also clears the missed-trigger flag), 2 = delay, 3 = width, 4 = divider.

Top module: `evt_pulse_chan`

## Requirements
- R1: Only an incoming code equal to all 8 bits of the selected code starts a pulse. Codes 0 to 255 can all be selected.
- R2: While the arm bit (control bit 0) is 0, matching codes start nothing and `busy_o` stays 0.
- R3: With divider 1, a match presented before clock edge k makes the pulse active from edge k+2+E up to edge k+2+E+W, where E is the effective delay and W is the width. `busy_o` is 1 during the wait and during the pulse.
- R4: The inactive output level equals the polarity bit (control bit 1). The active level is its inverse.
- R5: Divider values 0 and 1 both run the counters every clock. A divider P>1 stretches the pulse to W*P clocks and places its start between edge k+2+E*P and edge k+1+(E+1)*P.
- R6: The effective delay E is the programmed delay minus the offset entry of the matched code. Two codes whose offsets differ by the same amount as their programmed delays give the same pulse timing.
- R7: If the offset entry exceeds the programmed delay, E is 0.
- R8: A match that arrives while `busy_o` is 1 is ignored and sets `overrun_o`. The flag stays set until the control register is written.
- R9: A width of 0 produces no pulse and leaves `busy_o` at 0.
- R10: After reset, the output is low and both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_code_i | input | 8 | Event code for this clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 9 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| pulse_o | output | 1 | Trigger output |
| busy_o | output | 1 | Delay or pulse in progress |
| overrun_o | output | 1 | Sticky missed-trigger flag |

## Verification
The hardest case to reach is a second match landing while an earlier one is still waiting. It must be dropped without shifting or extending the pulse already under way. The stimulus fires the selected code, then fires it again three clocks later, inside a ten-tick delay. The bench checks that exactly one pulse of the original start and width appears and that the missed-trigger flag is set. The divided-clock cases are checked against a start window rather than a single edge, because the divider runs freely and its phase is unknown to the stimulus.

// File: rtl/evt_pulse_pkg.sv
package evt_pulse_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_PULSE} chan_state_e;

  localparam logic [2:0] REG_CODE  = 3'd0;
  localparam logic [2:0] REG_CTRL  = 3'd1;
  localparam logic [2:0] REG_DELAY = 3'd2;
  localparam logic [2:0] REG_WIDTH = 3'd3;
  localparam logic [2:0] REG_DIV   = 3'd4;
endpackage

// File: rtl/evt_offset_ram.sv
module evt_offset_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff = (div <= DIV_W'(1)) ? DIV_W'(1) : div;
    tick    = (cnt >= div_eff - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/evt_pulse_fsm.sv
module evt_pulse_fsm
  import evt_pulse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] load_dly,
  input  logic [CNT_W-1:0] width,
  output logic             busy,
  output logic             active
);
  chan_state_e      state;
  logic [CNT_W-1:0] dly_cnt;
  logic [CNT_W-1:0] wid_cnt;
  logic [CNT_W-1:0] wid_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      dly_cnt <= '0;
      wid_cnt <= '0;
      wid_lat <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_WAIT;
          dly_cnt <= load_dly;
          wid_lat <= width;
        end
        ST_WAIT: if (tick) begin
          if (dly_cnt == '0) begin
            state   <= ST_PULSE;
            wid_cnt <= wid_lat - CNT_W'(1);
          end else begin
            dly_cnt <= dly_cnt - CNT_W'(1);
          end
        end
        ST_PULSE: if (tick) begin
          if (wid_cnt == '0) state <= ST_IDLE;
          else               wid_cnt <= wid_cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (state != ST_IDLE);
    active = (state == ST_PULSE);
  end
endmodule

// File: rtl/evt_pulse_chan.sv
module evt_pulse_chan
  import evt_pulse_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              overrun_o
);
  logic [CODE_W-1:0] sel_q, code_q;
  logic              en_q, pol_q, ovr_q;
  logic [CNT_W-1:0]  dly_q, wid_q, off_q, load_dly;
  logic [DIV_W-1:0]  div_q;
  logic              tbl_we, reg_we, ctrl_wr;
  logic              code_match, hit, start, wid_nz;
  logic              tick, busy, active;

  always_comb begin
    tbl_we  = cfg_we_i &  cfg_addr_i[ADDR_W-1];
    reg_we  = cfg_we_i & ~cfg_addr_i[ADDR_W-1];
    ctrl_wr = reg_we & (cfg_addr_i[2:0] == REG_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      dly_q <= '0;
      wid_q <= '0;
      div_q <= '0;
    end else if (reg_we) begin
      case (cfg_addr_i[2:0])
        REG_CODE:  sel_q <= cfg_wdata_i[CODE_W-1:0];
        REG_CTRL:  {pol_q, en_q} <= cfg_wdata_i[1:0];
        REG_DELAY: dly_q <= cfg_wdata_i[CNT_W-1:0];
        REG_WIDTH: wid_q <= cfg_wdata_i[CNT_W-1:0];
        REG_DIV:   div_q <= cfg_wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  evt_offset_ram #(.ADDR_W(CODE_W), .DATA_W(CNT_W)) u_ofs (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (cfg_addr_i[CODE_W-1:0]),
    .wdata (cfg_wdata_i[CNT_W-1:0]),
    .raddr (evt_code_i),
    .rdata (off_q)
  );

  // code register aligned with the registered offset read
  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= evt_code_i;
  end

  always_comb begin
    code_match = (code_q == sel_q);
    hit        = en_q & code_match;
    wid_nz     = (wid_q != '0);
    start      = hit & ~busy & wid_nz;
    load_dly   = (dly_q > off_q) ? (dly_q - off_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr_q <= 1'b0;
    else if (ctrl_wr) ovr_q <= 1'b0;
    else if (hit & busy) ovr_q <= 1'b1;
  end

  evt_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .div  (div_q),
    .tick (tick)
  );

  evt_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start    (start),
    .load_dly (load_dly),
    .width    (wid_q),
    .busy     (busy),
    .active   (active)
  );

  always_comb begin
    pulse_o   = active ^ pol_q;
    busy_o    = busy;
    overrun_o = ovr_q;
  end
endmodule

// File: rtl/evt_pulse_chan_chk.sv
module evt_pulse_chan_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic overrun,
  input logic pulse,
  input logic pol,
  input logic en,
  input logic match,
  input logic wid_nz,
  input logic tick,
  input logic active
);
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(match)); // R1
  AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en)); // R2
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pulse == pol)); // R4
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($rose(active) || $fell(active)) |-> $past(tick)); // R5
  AST_OVERRUN_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(busy)); // R8
  AST_NO_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wid_nz)); // R9
  AST_END_FROM_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(active)); // R3
endmodule

bind evt_pulse_chan evt_pulse_chan_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy_o),
  .overrun (overrun_o),
  .pulse   (pulse_o),
  .pol     (pol_q),
  .en      (en_q),
  .match   (code_match),
  .wid_nz  (wid_nz),
  .tick    (tick),
  .active  (active)
);

// File: tb/evt_pulse_chan_test.sv
module evt_pulse_chan_test;
  localparam logic [7:0] IDLE_CODE = 8'h5A;
  localparam int WIN = 120;
  localparam int NVEC = 6;
  // {code, delay, width, offset, divider, polarity}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h10, 16'd5, 8'd3, 8'd0, 8'd1, 8'd0},
    {8'h20, 16'd9, 8'd4, 8'd4, 8'd0, 8'd0},
    {8'hFF, 16'd2, 8'd1, 8'd7, 8'd1, 8'd1},
    {8'h00, 16'd0, 8'd2, 8'd0, 8'd1, 8'd0},
    {8'h33, 16'd3, 8'd2, 8'd1, 8'd3, 8'd0},
    {8'h44, 16'd4, 8'd5, 8'd0, 8'd4, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_code = IDLE_CODE;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pulse_o, busy_o, overrun_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic cur_pol = 1'b0;

  always #4 clk = ~clk;

  evt_pulse_chan uut (
    .clk(clk), .rst(rst), .evt_code_i(evt_code), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pulse_o(pulse_o), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    n_chk++;
    if (act < exp_lo || act > exp_hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // fire code before edge 1; optional second fire after edge 'again'
  task automatic fire(input logic [7:0] code, input int again,
                      output int first, output int cnt, output int rises, output int busy_at4);
    logic prev = 1'b0;
    first = 0; cnt = 0; rises = 0; busy_at4 = 0;
    @(negedge clk); evt_code = code;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge clk);
      evt_code = (i == again) ? code : IDLE_CODE;
      if ((pulse_o ^ cur_pol) == 1'b1) begin
        if (!prev) begin rises++; if (first == 0) first = i; end
        cnt++;
      end
      prev = pulse_o ^ cur_pol;
      if (i == 4) busy_at4 = busy_o;
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f, c, r, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 pulse", pulse_o, 0, 0);
    check("R10 busy", busy_o, 0, 0);
    check("R10 overrun", overrun_o, 0, 0);

    // table-driven vectors: R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] code, wid, off, div, pol;
      logic [15:0] dly;
      int e, p;
      {code, dly, wid, off, div, pol} = VEC[v];
      e = (int'(dly) > int'(off)) ? int'(dly) - int'(off) : 0;  // R6 R7
      p = (div <= 1) ? 1 : int'(div);                            // R5
      wr({1'b1, code}, {8'd0, off});
      wr(9'd0, {8'd0, code});
      wr(9'd2, dly);
      wr(9'd3, {8'd0, wid});
      wr(9'd4, {8'd0, div});
      wr(9'd1, {14'd0, pol[0], 1'b1});
      cur_pol = pol[0];
      @(negedge clk);
      check("R4 idle level", pulse_o, pol[0], pol[0]);
      fire(code, 0, f, c, r, b);
      check("R3/R5/R6/R7 start", f, 3 + e * p, 2 + (e + 1) * p);
      check("R3/R5 width", c, int'(wid) * p, int'(wid) * p);
      check("R3 single pulse", r, 1, 1);
    end

    // back to full rate, code 0x10 (offset 0), polarity high-active
    wr(9'd0, 16'h0010);
    wr(9'd4, 16'd1);
    wr(9'd2, 16'd10);
    wr(9'd3, 16'd3);
    wr(9'd1, 16'd0);
    cur_pol = 1'b0;

    // R2 disarmed: matching code ignored
    fire(8'h10, 0, f, c, r, b);
    check("R2 no pulse", c, 0, 0);
    check("R2 not busy", b, 0, 0);

    // R1 near-miss codes ignored
    wr(9'd1, 16'd1);
    fire(8'h11, 0, f, c, r, b);
    check("R1 code 0x11", c, 0, 0);
    fire(8'h90, 0, f, c, r, b);
    check("R1 code 0x90", c, 0, 0);

    // R8 second match during wait
    fire(8'h10, 3, f, c, r, b);
    check("R8 start kept", f, 13, 13);
    check("R8 width kept", c, 3, 3);
    check("R8 one pulse", r, 1, 1);
    check("R3 busy in wait", b, 1, 1);
    check("R8 overrun set", overrun_o, 1, 1);
    wr(9'd1, 16'd1);
    check("R8 overrun cleared", overrun_o, 0, 0);

    // R9 zero width
    wr(9'd3, 16'd0);
    fire(8'h10, 0, f, c, r, b);
    check("R9 no pulse", c, 0, 0);
    check("R9 not busy", b, 0, 0);
    check("R9 no overrun", overrun_o, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule